// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the bus engine of a single-master I2C controller. A host issues one-shot commands (start, repeated start, transmit byte, receive byte, send acknowledge and stop), and the block turns each one into the matching sequence of levels on the two open-drain lines. It drives SDA and SCL only through active-high pull-low enables and reads both lines back. Because it reads SCL back, a target that holds the clock low stretches the high phase.

Every bus step advances on a one-cycle `tick` pulse from an external divider, so one tick period is a quarter of an SCL bit. Bytes move most significant bit first. On transmit, the ninth clock returns the target's acknowledge. On receive, a separate acknowledge command drives the ninth bit at a level the host chooses. The interrupt flag rises when each operation finishes. Only one operation runs at a time, and commands cannot be queued. A command issued while an operation is running is discarded. A data write that is not accepted also sets a sticky collision flag.

The host forms the first byte after a start itself: the target address in bits 7:1 and the direction in bit 0. The block sends that byte like any other.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), `busy`, `irq` and `wcol` are 0.
- R2: `cmd_start` from idle pulls SDA low while SCL is released, then pulls SCL low. Both lines stay pulled low afterwards.
- R3: `cmd_rstart` releases SDA, then SCL (waiting until SCL reads high), then pulls SDA low, then SCL low. No stop condition (SDA rising while SCL is high) appears on the bus during it.
- R4: `tx_wr` starts a 9-clock byte. `tx_data` bit 7 goes out on the first SCL high and bit 0 on the eighth. SDA is released on the ninth clock, and the SDA level sampled there is held in `ack_in` (0 = acknowledged). An address byte carries the address in bits 7:1 and the direction in bit 0 (0 write, 1 read).
- R5: `cmd_rx` runs 8 clocks with SDA released. The first sampled bit lands in `rx_data` bit 7 and the last in bit 0.
- R6: `cmd_ack` runs one clock and drives SDA to the level of `ack_level` (0 pulls SDA low).
- R7: `cmd_stop` pulls SDA low, releases SCL, then releases SDA while SCL reads high. Both lines end released.
- R8: `irq` becomes 1 the cycle after any operation completes and stays 1 until a cycle with `irq_clr` high. A completion in the same cycle wins over the clear.
- R9: A `tx_wr` that is not accepted is dropped and sets `wcol`. This happens when `busy` is 1, or when another command is accepted in the same cycle. `wcol` stays 1 until `wcol_clr`.
- R10: While `busy` is 1, commands are ignored. The running operation is neither ended nor changed by them.
- R11: During transmit, receive and acknowledge, SDA changes only while SCL is low.
- R12: After an operation completes, SCL keeps its level with no further edges until the next command.
- R13: While SCL reads low after the block has released it, the bit does not advance. The byte completes correctly once SCL is freed.
- R14: When several commands arrive together in idle, one is accepted in the order start, repeated start, stop, transmit, receive, acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Quarter-bit timing pulse from the SCL divider |
| cmd_start | input | 1 | One-cycle start request |
| cmd_rstart | input | 1 | One-cycle repeated start request |
| cmd_stop | input | 1 | One-cycle stop request |
| cmd_rx | input | 1 | One-cycle receive byte request |
| cmd_ack | input | 1 | One-cycle acknowledge request |
| tx_wr | input | 1 | One-cycle transmit buffer write |
| tx_data | input | DATA_W | Byte to transmit, sampled with `tx_wr` |
| ack_level | input | 1 | SDA level for the acknowledge bit, sampled with `cmd_ack` |
| irq_clr | input | 1 | Clears `irq` |
| wcol_clr | input | 1 | Clears `wcol` |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| rx_data | output | DATA_W | Last received byte |
| ack_in | output | 1 | Acknowledge level sampled on the last transmit |
| busy | output | 1 | An operation is running |
| irq | output | 1 | Operation-complete flag |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
Transmit bytes are a fixed address byte plus random values, each paired with a random target acknowledge. A swapped bit order, a lost bit or a wrong ninth-clock sample then shows up in the captured SCL-rising-edge bits and in `ack_in`. Receive uses random bytes supplied by a bench target, and each is followed by an acknowledge of random level. This separates the receive shift direction from the acknowledge drive level. Collision and rejection are probed with writes and commands landing mid-byte and in the same cycle as another command. Start, stop and repeated start are told apart by counting SDA edges while SCL is high, and a stretched clock shows whether the high phase waits for the line.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        C_NONE,
        C_START,
        C_RSTART,
        C_STOP,
        C_TX,
        C_RX,
        C_ACK
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RSTART,
        ST_STOP,
        ST_BITS
    } seq_state_e;

    typedef enum logic [1:0] {
        BM_TX,
        BM_RX,
        BM_ACK
    } bit_mode_e;

    typedef struct packed {
        logic irq;
        logic wcol;
    } flag_t;

endpackage

// File: rtl/i2cm_cmd_decode.sv
module i2cm_cmd_decode
    import i2cm_pkg::*;
(
    input  logic busy,
    input  logic cmd_start,
    input  logic cmd_rstart,
    input  logic cmd_stop,
    input  logic tx_wr,
    input  logic cmd_rx,
    input  logic cmd_ack,
    output cmd_e acc_cmd,
    output logic wr_drop
);

    always_comb begin
        acc_cmd = C_NONE;
        if (!busy) begin
            if (cmd_start)       acc_cmd = C_START;
            else if (cmd_rstart) acc_cmd = C_RSTART;
            else if (cmd_stop)   acc_cmd = C_STOP;
            else if (tx_wr)      acc_cmd = C_TX;
            else if (cmd_rx)     acc_cmd = C_RX;
            else if (cmd_ack)    acc_cmd = C_ACK;
        end
        // a buffer write that did not become the accepted command is lost
        wr_drop = tx_wr && (acc_cmd != C_TX);
    end

endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags
    import i2cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic irq_clr,
    input  logic wr_drop,
    input  logic wcol_clr,
    output logic irq,
    output logic wcol
);

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d      = flg_q;
        flg_d.irq  = done    | (flg_q.irq  & ~irq_clr);
        flg_d.wcol = wr_drop | (flg_q.wcol & ~wcol_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign irq  = flg_q.irq;
    assign wcol = flg_q.wcol;

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  cmd_e              acc_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_level,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              ack_in,
    output logic              in_byte,
    output logic              in_rstart
);

    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_RX  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_ACK = '0;

    typedef struct packed {
        seq_state_e        st;
        bit_mode_e         mode;
        logic [1:0]        ph;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] rx;
        logic              ack;
        logic              sda;
        logic              scl;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] last_idx;
    logic             last_bit;

    always_comb begin
        unique case (seq_q.mode)
            BM_TX:   last_idx = LAST_TX;
            BM_RX:   last_idx = LAST_RX;
            default: last_idx = LAST_ACK;
        endcase
        last_bit = (seq_q.cnt == last_idx);
    end

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.ph  = 2'd0;
                seq_d.cnt = '0;
                unique case (acc_cmd)
                    C_START:  seq_d.st = ST_START;
                    C_RSTART: seq_d.st = ST_RSTART;
                    C_STOP:   seq_d.st = ST_STOP;
                    C_TX: begin
                        seq_d.st   = ST_BITS;
                        seq_d.mode = BM_TX;
                        seq_d.sh   = {wdata, 1'b1};
                    end
                    C_RX: begin
                        seq_d.st   = ST_BITS;
                        seq_d.mode = BM_RX;
                        seq_d.sh   = '1;
                    end
                    C_ACK: begin
                        seq_d.st   = ST_BITS;
                        seq_d.mode = BM_ACK;
                        seq_d.sh   = {ack_level, {DATA_W{1'b1}}};
                    end
                    default: ;
                endcase
            end
            ST_START: if (tick) begin
                if (seq_q.ph == 2'd0) begin
                    seq_d.sda = 1'b0;
                    seq_d.ph  = 2'd1;
                end else begin
                    seq_d.scl = 1'b0;
                    seq_d.st  = ST_IDLE;
                    done      = 1'b1;
                end
            end
            ST_RSTART: if (tick) begin
                unique case (seq_q.ph)
                    2'd0: begin seq_d.sda = 1'b1; seq_d.ph = 2'd1; end
                    2'd1: begin seq_d.scl = 1'b1; seq_d.ph = 2'd2; end
                    2'd2: if (scl_in) begin
                        seq_d.sda = 1'b0;
                        seq_d.ph  = 2'd3;
                    end
                    default: begin
                        seq_d.scl = 1'b0;
                        seq_d.st  = ST_IDLE;
                        done      = 1'b1;
                    end
                endcase
            end
            ST_STOP: if (tick) begin
                unique case (seq_q.ph)
                    2'd0: begin seq_d.sda = 1'b0; seq_d.ph = 2'd1; end
                    2'd1: begin seq_d.scl = 1'b1; seq_d.ph = 2'd2; end
                    default: if (scl_in) begin
                        seq_d.sda = 1'b1;
                        seq_d.st  = ST_IDLE;
                        done      = 1'b1;
                    end
                endcase
            end
            ST_BITS: if (tick) begin
                unique case (seq_q.ph)
                    2'd0: begin
                        // never move SDA while SCL is released
                        if (seq_q.scl) begin
                            seq_d.scl = 1'b0;
                        end else begin
                            seq_d.sda = seq_q.sh[SH_W-1];
                            seq_d.ph  = 2'd1;
                        end
                    end
                    2'd1: begin seq_d.scl = 1'b1; seq_d.ph = 2'd2; end
                    2'd2: if (scl_in) begin
                        if (seq_q.mode == BM_RX)
                            seq_d.rx = {seq_q.rx[DATA_W-2:0], sda_in};
                        if (seq_q.mode == BM_TX && last_bit)
                            seq_d.ack = sda_in;
                        seq_d.ph = 2'd3;
                    end
                    default: begin
                        seq_d.scl = 1'b0;
                        seq_d.sh  = {seq_q.sh[SH_W-2:0], 1'b1};
                        seq_d.ph  = 2'd0;
                        if (last_bit) begin
                            seq_d.st = ST_IDLE;
                            done     = 1'b1;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                endcase
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.mode <= BM_TX;
            seq_q.ph   <= 2'd0;
            seq_q.cnt  <= '0;
            seq_q.sh   <= '1;
            seq_q.rx   <= '0;
            seq_q.ack  <= 1'b0;
            seq_q.sda  <= 1'b1;
            seq_q.scl  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sda_oe    = ~seq_q.sda;
    assign scl_oe    = ~seq_q.scl;
    assign busy      = (seq_q.st != ST_IDLE);
    assign rx_data   = seq_q.rx;
    assign ack_in    = seq_q.ack;
    assign in_byte   = (seq_q.st == ST_BITS);
    assign in_rstart = (seq_q.st == ST_RSTART);

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rx,
    input  logic              cmd_ack,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ack_level,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              ack_in,
    output logic              busy,
    output logic              irq,
    output logic              wcol
);

    cmd_e acc_cmd;
    logic wr_drop;
    logic done;
    logic in_byte;
    logic in_rstart;

    i2cm_cmd_decode u_dec (
        .busy       (busy),
        .cmd_start  (cmd_start),
        .cmd_rstart (cmd_rstart),
        .cmd_stop   (cmd_stop),
        .tx_wr      (tx_wr),
        .cmd_rx     (cmd_rx),
        .cmd_ack    (cmd_ack),
        .acc_cmd    (acc_cmd),
        .wr_drop    (wr_drop)
    );

    i2cm_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .acc_cmd   (acc_cmd),
        .wdata     (tx_data),
        .ack_level (ack_level),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .ack_in    (ack_in),
        .in_byte   (in_byte),
        .in_rstart (in_rstart)
    );

    i2cm_flags u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .irq_clr  (irq_clr),
        .wr_drop  (wr_drop),
        .wcol_clr (wcol_clr),
        .irq      (irq),
        .wcol     (wcol)
    );

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic irq_clr,
    input logic wcol_clr,
    input logic sda_oe,
    input logic scl_oe,
    input logic busy,
    input logic irq,
    input logic wcol,
    input logic done,
    input logic in_byte,
    input logic in_rstart
);

    // R9: a write while busy leaves the collision flag set
    a_r9_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> wcol);

    // R9: the collision flag holds until cleared
    a_r9_wcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !wcol_clr) |=> wcol);

    // R8: completion raises the interrupt flag
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);

    // R8: clear without completion drops the flag
    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !done) |=> !irq);

    // R11: SDA steady while SCL released inside a bit operation
    a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && $past(in_byte) && !scl_oe && !$past(scl_oe))
            |-> (sda_oe == $past(sda_oe)));

    // R3: no SDA rise with SCL released during a repeated start
    a_r3_no_stop_in_rstart: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rstart && $past(in_rstart) && !scl_oe && !$past(scl_oe))
            |-> !($past(sda_oe) && !sda_oe));

    // R10: nothing but completion ends a running operation
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R12: SCL frozen while idle
    a_r12_scl_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(scl_oe));

endmodule

bind i2c_cmd_master i2cm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_wr     (tx_wr),
    .irq_clr   (irq_clr),
    .wcol_clr  (wcol_clr),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe),
    .busy      (busy),
    .irq       (irq),
    .wcol      (wcol),
    .done      (done),
    .in_byte   (in_byte),
    .in_rstart (in_rstart)
);

// File: tb/i2c_cmd_master_test.sv
`timescale 1ns/1ps
module i2c_cmd_master_test;

    localparam int DW = 8;
    localparam int OP_START = 0, OP_RSTART = 1, OP_STOP = 2, OP_TX = 3, OP_RX = 4, OP_ACK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rx = 0, cmd_ack = 0, tx_wr = 0;
    logic [DW-1:0] tx_data = '0;
    logic ack_level = 0, irq_clr = 0, wcol_clr = 0;
    logic sda_oe, scl_oe, ack_in, busy, irq, wcol;
    logic [DW-1:0] rx_data;
    logic stretch = 0;
    logic slv_pull = 0;
    logic sda_line, scl_line;

    assign scl_line = ~scl_oe & ~stretch;
    assign sda_line = ~sda_oe & ~slv_pull;

    i2c_cmd_master #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_rx(cmd_rx), .cmd_ack(cmd_ack), .tx_wr(tx_wr), .tx_data(tx_data),
        .ack_level(ack_level), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
        .sda_in(sda_line), .scl_in(scl_line),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .rx_data(rx_data), .ack_in(ack_in),
        .busy(busy), .irq(irq), .wcol(wcol)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // bus monitor and bench target
    int rises = 0, falls = 0, starts = 0, stops = 0, hi_chg = 0;
    logic [8:0] cap = '0;
    logic prv_scl = 1'b1, prv_sda = 1'b1;
    int slv_mode = 0;
    int slv_base = 0;
    logic [7:0] slv_byte = '0;
    logic slv_ack = 1'b0;

    always @(negedge clk) begin
        int k;
        if (rst_n) begin
            if (scl_line && !prv_scl) begin
                rises = rises + 1;
                cap = {cap[7:0], sda_line};
            end
            if (!scl_line && prv_scl) falls = falls + 1;
            if (scl_line && prv_scl && prv_sda && !sda_line) starts = starts + 1;
            if (scl_line && prv_scl && !prv_sda && sda_line) stops = stops + 1;
            if (scl_line && prv_scl && (prv_sda != sda_line)) hi_chg = hi_chg + 1;
        end
        prv_scl = scl_line;
        prv_sda = sda_line;
        k = falls - slv_base;
        if (slv_mode == 1)      slv_pull = (k == 8) && !slv_ack;
        else if (slv_mode == 2) slv_pull = (k < 8) ? ~slv_byte[7 - k] : 1'b0;
        else                    slv_pull = 1'b0;
    end

    int nchk = 0, nerr = 0;
    int b_rises, b_starts, b_stops, b_hi;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic snap(input int mode);
        b_rises  = rises;
        b_starts = starts;
        b_stops  = stops;
        b_hi     = hi_chg;
        slv_base = falls;
        slv_mode = mode;
    endtask

    task automatic issue(input int op, input logic [7:0] v);
        @(negedge clk);
        case (op)
            OP_START:  cmd_start = 1;
            OP_RSTART: cmd_rstart = 1;
            OP_STOP:   cmd_stop = 1;
            OP_TX:     begin tx_wr = 1; tx_data = v; end
            OP_RX:     cmd_rx = 1;
            default:   begin cmd_ack = 1; ack_level = v[0]; end
        endcase
        @(negedge clk);
        cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; tx_wr = 0; cmd_rx = 0; cmd_ack = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!irq && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R8 irq set on completion"}, irq, 1);
        chk({tag, " R10 busy low after completion"}, busy, 0);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        chk({tag, " R8 irq cleared"}, irq, 0);
    endtask

    function automatic logic [8:0] exp_tx_cap(input logic [7:0] b, input logic a);
        return {b, a};
    endfunction

    task automatic tx_byte(input logic [7:0] b, input logic a, input string tag);
        snap(1);
        slv_ack = a;
        issue(OP_TX, b);
        wait_done(tag);
        chk({tag, " R4 bits msb first"}, int'(cap), int'(exp_tx_cap(b, a)));
        chk({tag, " R4 ack sampled"}, ack_in, a);
        chk({tag, " R4 nine clocks"}, rises - b_rises, 9);
        chk({tag, " R11 sda steady while scl high"}, hi_chg - b_hi, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wcol", wcol, 0);

        // start
        snap(0);
        issue(OP_START, 8'h0);
        chk("R2 busy after accept", busy, 1);
        wait_done("start");
        chk("R2 one start condition", starts - b_starts, 1);
        chk("R2 sda held low", sda_oe, 1);
        chk("R2 scl held low", scl_oe, 1);

        // address byte: address 0x51, direction read
        tx_byte({7'h51, 1'b1}, 1'b0, "addr");

        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            logic a;
            b = 8'($urandom);
            a = 1'($urandom);
            tx_byte(b, a, "tx rand");
        end

        // R12 hold
        snap(0);
        repeat (60) @(negedge clk);
        chk("R12 no scl edge after completion", rises - b_rises, 0);
        chk("R12 scl still held", scl_oe, 1);

        // receive with acknowledge
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            logic l;
            b = 8'($urandom);
            l = (i == 3) ? 1'b1 : 1'($urandom);
            snap(0);
            slv_byte = b;
            slv_mode = 2;
            issue(OP_RX, 8'h0);
            wait_done("rx");
            chk("R5 received byte", rx_data, b);
            chk("R5 eight clocks", rises - b_rises, 8);
            chk("R11 rx sda steady while scl high", hi_chg - b_hi, 0);
            snap(0);
            issue(OP_ACK, {7'h0, l});
            wait_done("ack");
            chk("R6 ack level on bus", cap[0], l);
            chk("R6 one clock", rises - b_rises, 1);
        end

        // collision: write during a byte
        begin
            logic [7:0] b1, b2;
            b1 = 8'($urandom);
            b2 = ~b1;
            snap(1);
            slv_ack = 1'b0;
            issue(OP_TX, b1);
            repeat (10) @(negedge clk);
            issue(OP_TX, b2);
            chk("R9 wcol set by busy write", wcol, 1);
            wait_done("wcol");
            chk("R9 dropped write leaves byte intact", int'(cap), int'(exp_tx_cap(b1, 1'b0)));
            chk("R9 no second byte", rises - b_rises, 9);
            chk("R9 wcol still set", wcol, 1);
            @(negedge clk);
            wcol_clr = 1;
            @(negedge clk);
            wcol_clr = 0;
            chk("R9 wcol cleared", wcol, 0);
        end

        // commands while busy are ignored
        begin
            logic [7:0] b;
            b = 8'($urandom);
            snap(1);
            slv_ack = 1'b1;
            issue(OP_TX, b);
            repeat (12) @(negedge clk);
            issue(OP_STOP, 8'h0);
            issue(OP_START, 8'h0);
            issue(OP_RX, 8'h0);
            wait_done("reject");
            chk("R10 byte unaffected", int'(cap), int'(exp_tx_cap(b, 1'b1)));
            repeat (40) @(negedge clk);
            chk("R10 no stop issued", stops - b_stops, 0);
            chk("R10 no start issued", starts - b_starts, 0);
            chk("R10 wcol untouched", wcol, 0);
        end

        // repeated start
        snap(0);
        issue(OP_RSTART, 8'h0);
        wait_done("rstart");
        chk("R3 one start condition", starts - b_starts, 1);
        chk("R3 no stop condition", stops - b_stops, 0);
        chk("R3 sda held low", sda_oe, 1);
        chk("R3 scl held low", scl_oe, 1);

        // clock stretching
        begin
            logic [7:0] b;
            b = 8'($urandom);
            snap(1);
            slv_ack = 1'b0;
            stretch = 1;
            issue(OP_TX, b);
            repeat (80) @(negedge clk);
            chk("R13 waits while scl held", busy, 1);
            chk("R13 no rise while held", rises - b_rises, 0);
            stretch = 0;
            wait_done("stretch");
            chk("R13 byte after stretch", int'(cap), int'(exp_tx_cap(b, 1'b0)));
        end

        // stop together with a write: stop wins, write collides
        snap(0);
        @(negedge clk);
        cmd_stop = 1;
        tx_wr = 1;
        tx_data = 8'hA5;
        @(negedge clk);
        cmd_stop = 0;
        tx_wr = 0;
        chk("R14 stop taken over write", busy, 1);
        chk("R9 same cycle write collides", wcol, 1);
        wait_done("stop");
        chk("R7 one stop condition", stops - b_stops, 1);
        chk("R14 no data clocks", rises - b_rises, 1);
        chk("R7 sda released", sda_oe, 0);
        chk("R7 scl released", scl_oe, 0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule